// File: doc/BRIEF.md
# Restartable Block Word Copier

This block moves a counted run of words from one memory region to another, one word per iteration, over a single request/acknowledge memory port. The live word count, source pointer, destination pointer and offset sit in registers that are visible at the ports. Software hands these values back on a later start, so an interrupted copy picks up exactly where it stopped.

After every completed word the block samples a pending-interrupt input. If that input is high, the block yields with its registers left consistent, so a restart resumes the copy without repeating or skipping a word. A memory error on either access of a word puts the registers back to their values from before that word, and the block yields. The same restart then retries that word.

The copier has two addressing modes, chosen at start. In plain mode both pointers advance. In long mode both pointers stay fixed, and a shared offset advances instead. That offset is added to each pointer, and a separate high-address field is placed above the destination address.

The state machine has these states: IDLE, CHECK, READ, WRITE, ADVANCE, FINISH and YIELD. It has these transitions:
- IDLE to CHECK on start.
- CHECK to FINISH when the count is zero.
- CHECK to READ otherwise, and the count is decremented.
- READ to WRITE on a clean acknowledge.
- WRITE to ADVANCE on a clean acknowledge.
- READ or WRITE to YIELD on an acknowledge with error.
- ADVANCE to YIELD when an interrupt is pending.
- ADVANCE to CHECK otherwise.
- FINISH and YIELD back to IDLE.

Top module: `blkcopy_engine`

## Requirements
- R1: After reset `done`, `suspended` and `mem_req` are low, and `cur_cnt`, `cur_src`, `cur_dst` and `cur_off` are zero.
- R2: A start with a count of zero gives a `done` pulse and makes no memory request. `done` is only ever raised while `cur_cnt` is zero.
- R3: Each word is copied by one read request (`mem_we`=0) followed by one write request (`mem_we`=1). The write data equals the word read. A request holds `mem_req` and `mem_we` until `mem_ack`.
- R4: In plain mode (`start_long`=0) word k is read from address {0, src+k} and written to {0, dst+k}, with the upper HI_W address bits zero. After each completed word, `cur_src` and `cur_dst` have each grown by one, `cur_cnt` has dropped by one, and `cur_off` is unchanged.
- R5: In long mode (`start_long`=1) word k is read from {0, src+off+k} and written to {dhi, dst+off+k}. Sums wrap modulo 2^AW. After each completed word, `cur_off` has grown by one and `cur_cnt` has dropped by one, while `cur_src` and `cur_dst` stay fixed.
- R6: After each completed word, a high `irq_pend` makes the block pulse `suspended` instead of fetching the next word. With `irq_pend` held high, each start of a nonzero count copies exactly one word.
- R7: Restarting with the exposed `cur_*` values, repeated until `done`, writes every destination word exactly once with the right data, and writes nothing past the last one.
- R8: An acknowledge with `mem_err` high makes the block pulse `suspended` on the next cycle. The registers then hold their values from before that word, and a failed write leaves the destination unchanged.
- R9: `done` and `suspended` are one-cycle pulses and are never high together.
- R10: A `start` received while a copy is running is ignored. The running copy completes with its original parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin or resume a copy (taken only when idle) |
| start_long | input | 1 | 1 selects long (shared-offset) addressing |
| start_src | input | AW | Source pointer to load |
| start_dst | input | AW | Destination pointer to load |
| start_dhi | input | HI_W | Destination high-address field (long mode) |
| start_off | input | AW | Shared offset to load (long mode) |
| start_cnt | input | CW | Words remaining to load |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW+HI_W | Memory word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Request completed |
| mem_err | input | 1 | Completed request failed (with `mem_ack`) |
| irq_pend | input | 1 | Interrupt pending; sampled after each word |
| done | output | 1 | Pulse: copy finished |
| suspended | output | 1 | Pulse: copy yielded, registers resumable |
| cur_src | output | AW | Live source pointer |
| cur_dst | output | AW | Live destination pointer |
| cur_off | output | AW | Live shared offset |
| cur_cnt | output | CW | Live remaining count |

## Verification
Some properties are checked on every cycle:
- The two end pulses are exclusive and last one cycle.
- `done` only rises while the count is zero, and never while a request is open.
- A clean read acknowledge is followed at once by a write request.
- A request is held until it is acknowledged.
- An errored acknowledge is followed by a yield.

Other behaviour is shown only by the bench's scenarios. These are the exact read and write addresses in each mode, the data moved, register values after a rollback, the one-word progress under a held interrupt, the ignored mid-copy start, and the final memory image after many suspend-and-resume rounds.

// File: rtl/blkcopy_pkg.sv
package blkcopy_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_CHECK   = 3'd1,
        ST_READ    = 3'd2,
        ST_WRITE   = 3'd3,
        ST_ADVANCE = 3'd4,
        ST_FINISH  = 3'd5,
        ST_YIELD   = 3'd6
    } bc_state_e;

endpackage

// File: rtl/blkcopy_fsm.sv
module blkcopy_fsm
    import blkcopy_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cnt_zero,
    input  logic mem_ack,
    input  logic mem_err,
    input  logic irq_pend,
    output logic load_en,
    output logic dec_en,
    output logic cap_en,
    output logic step_en,
    output logic undo_en,
    output logic mem_req,
    output logic mem_we,
    output logic done,
    output logic suspended
);

    bc_state_e state_q;
    bc_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_CHECK;
            end
            ST_CHECK: begin
                state_d = cnt_zero ? ST_FINISH : ST_READ;
            end
            ST_READ: begin
                if (mem_ack) state_d = mem_err ? ST_YIELD : ST_WRITE;
            end
            ST_WRITE: begin
                if (mem_ack) state_d = mem_err ? ST_YIELD : ST_ADVANCE;
            end
            ST_ADVANCE: begin
                state_d = irq_pend ? ST_YIELD : ST_CHECK;
            end
            ST_FINISH: state_d = ST_IDLE;
            ST_YIELD:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs and datapath strobes
    always_comb begin
        load_en   = 1'b0;
        dec_en    = 1'b0;
        cap_en    = 1'b0;
        step_en   = 1'b0;
        undo_en   = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        done      = 1'b0;
        suspended = 1'b0;
        unique case (state_q)
            ST_IDLE:    load_en = start;
            ST_CHECK:   dec_en  = !cnt_zero;
            ST_READ: begin
                mem_req = 1'b1;
                cap_en  = mem_ack && !mem_err;
                undo_en = mem_ack && mem_err;
            end
            ST_WRITE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                undo_en = mem_ack && mem_err;
            end
            ST_ADVANCE: step_en   = 1'b1;
            ST_FINISH:  done      = 1'b1;
            ST_YIELD:   suspended = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/blkcopy_regs.sv
module blkcopy_regs #(
    parameter int AW   = 16,
    parameter int HI_W = 8,
    parameter int DW   = 16,
    parameter int CW   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_en,
    input  logic            dec_en,
    input  logic            cap_en,
    input  logic            step_en,
    input  logic            undo_en,
    input  logic            ld_long,
    input  logic [AW-1:0]   ld_src,
    input  logic [AW-1:0]   ld_dst,
    input  logic [HI_W-1:0] ld_dhi,
    input  logic [AW-1:0]   ld_off,
    input  logic [CW-1:0]   ld_cnt,
    input  logic [DW-1:0]   rd_word,
    output logic            long_q,
    output logic [AW-1:0]   src_q,
    output logic [AW-1:0]   dst_q,
    output logic [HI_W-1:0] dhi_q,
    output logic [AW-1:0]   off_q,
    output logic [CW-1:0]   cnt_q,
    output logic [DW-1:0]   data_q,
    output logic            cnt_zero
);

    logic [CW-1:0] cnt_save_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            long_q     <= 1'b0;
            src_q      <= '0;
            dst_q      <= '0;
            dhi_q      <= '0;
            off_q      <= '0;
            cnt_q      <= '0;
            cnt_save_q <= '0;
            data_q     <= '0;
        end else begin
            if (load_en) begin
                long_q <= ld_long;
                src_q  <= ld_src;
                dst_q  <= ld_dst;
                dhi_q  <= ld_dhi;
                off_q  <= ld_off;
                cnt_q  <= ld_cnt;
            end
            if (dec_en) begin
                cnt_save_q <= cnt_q;
                cnt_q      <= cnt_q - CW'(1);
            end
            if (cap_en) begin
                data_q <= rd_word;
            end
            if (undo_en) begin
                // pointers only move in ADVANCE, so the count is the only undo
                cnt_q <= cnt_save_q;
            end
            if (step_en) begin
                if (long_q) begin
                    off_q <= off_q + AW'(1);
                end else begin
                    src_q <= src_q + AW'(1);
                    dst_q <= dst_q + AW'(1);
                end
            end
        end
    end

    assign cnt_zero = (cnt_q == '0);

endmodule

// File: rtl/blkcopy_agen.sv
module blkcopy_agen #(
    parameter int AW      = 16,
    parameter int HI_W    = 8,
    parameter bit LONG_EN = 1'b1
) (
    input  logic               long_q,
    input  logic               we,
    input  logic [AW-1:0]      src_q,
    input  logic [AW-1:0]      dst_q,
    input  logic [HI_W-1:0]    dhi_q,
    input  logic [AW-1:0]      off_q,
    output logic [AW+HI_W-1:0] addr
);

    localparam int LAW = AW + HI_W;

    logic [LAW-1:0] rd_addr;
    logic [LAW-1:0] wr_addr;

    generate
        if (LONG_EN) begin : g_long
            logic [AW-1:0] src_eff;
            logic [AW-1:0] dst_eff;
            assign src_eff = long_q ? (src_q + off_q) : src_q;
            assign dst_eff = long_q ? (dst_q + off_q) : dst_q;
            assign rd_addr = {{HI_W{1'b0}}, src_eff};
            assign wr_addr = {(long_q ? dhi_q : {HI_W{1'b0}}), dst_eff};
        end else begin : g_plain
            logic unused_long;
            assign unused_long = long_q ^ (^dhi_q) ^ (^off_q);
            assign rd_addr = {{HI_W{1'b0}}, src_q};
            assign wr_addr = {{HI_W{1'b0}}, dst_q};
        end
    endgenerate

    assign addr = we ? wr_addr : rd_addr;

endmodule

// File: rtl/blkcopy_engine.sv
module blkcopy_engine #(
    parameter int AW      = 16,
    parameter int HI_W    = 8,
    parameter int DW      = 16,
    parameter int CW      = 16,
    parameter bit LONG_EN = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               start_long,
    input  logic [AW-1:0]      start_src,
    input  logic [AW-1:0]      start_dst,
    input  logic [HI_W-1:0]    start_dhi,
    input  logic [AW-1:0]      start_off,
    input  logic [CW-1:0]      start_cnt,
    output logic               mem_req,
    output logic               mem_we,
    output logic [AW+HI_W-1:0] mem_addr,
    output logic [DW-1:0]      mem_wdata,
    input  logic [DW-1:0]      mem_rdata,
    input  logic               mem_ack,
    input  logic               mem_err,
    input  logic               irq_pend,
    output logic               done,
    output logic               suspended,
    output logic [AW-1:0]      cur_src,
    output logic [AW-1:0]      cur_dst,
    output logic [AW-1:0]      cur_off,
    output logic [CW-1:0]      cur_cnt
);

    logic            load_en;
    logic            dec_en;
    logic            cap_en;
    logic            step_en;
    logic            undo_en;
    logic            cnt_zero;
    logic            long_q;
    logic [HI_W-1:0] dhi_q;

    blkcopy_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cnt_zero  (cnt_zero),
        .mem_ack   (mem_ack),
        .mem_err   (mem_err),
        .irq_pend  (irq_pend),
        .load_en   (load_en),
        .dec_en    (dec_en),
        .cap_en    (cap_en),
        .step_en   (step_en),
        .undo_en   (undo_en),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .done      (done),
        .suspended (suspended)
    );

    blkcopy_regs #(
        .AW   (AW),
        .HI_W (HI_W),
        .DW   (DW),
        .CW   (CW)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .dec_en   (dec_en),
        .cap_en   (cap_en),
        .step_en  (step_en),
        .undo_en  (undo_en),
        .ld_long  (start_long),
        .ld_src   (start_src),
        .ld_dst   (start_dst),
        .ld_dhi   (start_dhi),
        .ld_off   (start_off),
        .ld_cnt   (start_cnt),
        .rd_word  (mem_rdata),
        .long_q   (long_q),
        .src_q    (cur_src),
        .dst_q    (cur_dst),
        .dhi_q    (dhi_q),
        .off_q    (cur_off),
        .cnt_q    (cur_cnt),
        .data_q   (mem_wdata),
        .cnt_zero (cnt_zero)
    );

    blkcopy_agen #(
        .AW      (AW),
        .HI_W    (HI_W),
        .LONG_EN (LONG_EN)
    ) u_agen (
        .long_q (long_q),
        .we     (mem_we),
        .src_q  (cur_src),
        .dst_q  (cur_dst),
        .dhi_q  (dhi_q),
        .off_q  (cur_off),
        .addr   (mem_addr)
    );

endmodule

// File: rtl/blkcopy_chk.sv
module blkcopy_chk (
    input logic clk,
    input logic rst_n,
    input logic mem_req,
    input logic mem_we,
    input logic mem_ack,
    input logic mem_err,
    input logic done,
    input logic suspended,
    input logic cnt_is_zero
);

    p_pulse_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && suspended));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_susp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        suspended |=> !suspended);

    p_done_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cnt_is_zero && !mem_req));

    p_rd_then_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack && !mem_err) |=> (mem_req && mem_we));

    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we)));

    p_err_yield_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_err) |=> (suspended && !mem_req));

endmodule

bind blkcopy_engine blkcopy_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_ack     (mem_ack),
    .mem_err     (mem_err),
    .done        (done),
    .suspended   (suspended),
    .cnt_is_zero (cur_cnt == '0)
);

// File: tb/blkcopy_engine_tb.sv
module blkcopy_engine_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW   = 8;
    localparam int HI_W = 2;
    localparam int DW   = 16;
    localparam int CW   = 8;
    localparam int LAW  = AW + HI_W;
    localparam int MEMN = 1 << LAW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            start_long = 1'b0;
    logic [AW-1:0]   start_src = '0;
    logic [AW-1:0]   start_dst = '0;
    logic [HI_W-1:0] start_dhi = '0;
    logic [AW-1:0]   start_off = '0;
    logic [CW-1:0]   start_cnt = '0;
    logic            mem_req;
    logic            mem_we;
    logic [LAW-1:0]  mem_addr;
    logic [DW-1:0]   mem_wdata;
    logic [DW-1:0]   mem_rdata = '0;
    logic            mem_ack = 1'b0;
    logic            mem_err = 1'b0;
    logic            irq_pend = 1'b0;
    logic            done;
    logic            suspended;
    logic [AW-1:0]   cur_src;
    logic [AW-1:0]   cur_dst;
    logic [AW-1:0]   cur_off;
    logic [CW-1:0]   cur_cnt;

    blkcopy_engine #(.AW(AW), .HI_W(HI_W), .DW(DW), .CW(CW), .LONG_EN(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_long(start_long),
        .start_src(start_src), .start_dst(start_dst), .start_dhi(start_dhi),
        .start_off(start_off), .start_cnt(start_cnt),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .mem_err(mem_err), .irq_pend(irq_pend), .done(done),
        .suspended(suspended), .cur_src(cur_src), .cur_dst(cur_dst),
        .cur_off(cur_off), .cur_cnt(cur_cnt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;

    logic [DW-1:0] mem  [MEMN];
    logic [DW-1:0] gold [MEMN];

    int j_long, j_src, j_dst, j_dhi, j_off, j_cnt;
    int w_cnt = 0;
    int acc_cnt = 0;
    int err_cd = -1;
    int err_fired = 0;
    int wait_left = 0;
    int irq_mode = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int exp_rd(int w);
        if (j_long != 0) return (j_src + j_off + w) & 255;
        return (j_src + w) & 255;
    endfunction

    function automatic int exp_wr(int w);
        if (j_long != 0) return j_dhi * 256 + ((j_dst + j_off + w) & 255);
        return (j_dst + w) & 255;
    endfunction

    // Memory model with random latency and error injection
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            mem_err <= 1'b0;
        end else if (mem_ack) begin
            mem_ack   <= 1'b0;
            mem_err   <= 1'b0;
            wait_left = int'($urandom % 3);
        end else if (mem_req) begin
            if (wait_left > 0) begin
                wait_left = wait_left - 1;
            end else begin
                acc_cnt++;
                mem_ack <= 1'b1;
                if (err_cd == 0) begin
                    mem_err   <= 1'b1;
                    err_cd    = -1;
                    err_fired = 1;
                end else begin
                    if (err_cd > 0) err_cd--;
                    if (!mem_we) begin
                        chk(int'(mem_addr) == exp_rd(w_cnt), (j_long != 0) ? "R5" : "R4",
                            "read address", mem_addr, exp_rd(w_cnt));
                        mem_rdata <= mem[mem_addr];
                    end else begin
                        chk(int'(mem_addr) == exp_wr(w_cnt), (j_long != 0) ? "R5" : "R4",
                            "write address", mem_addr, exp_wr(w_cnt));
                        chk(mem_wdata == gold[exp_rd(w_cnt)], "R3", "write data",
                            mem_wdata, gold[exp_rd(w_cnt)]);
                        mem[mem_addr] = mem_wdata;
                        w_cnt++;
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (irq_mode == 1)      irq_pend <= 1'b1;
        else if (irq_mode == 2) irq_pend <= (($urandom % 4) == 0);
        else                    irq_pend <= 1'b0;
    end

    task automatic pulse_start(input int lng, input int s, input int d, input int h,
                               input int o, input int c);
        @(negedge clk);
        start      = 1'b1;
        start_long = lng[0];
        start_src  = AW'(s);
        start_dst  = AW'(d);
        start_dhi  = HI_W'(h);
        start_off  = AW'(o);
        start_cnt  = CW'(c);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic check_regs(input string tag);
        int w = w_cnt;
        chk(int'(cur_cnt) == j_cnt - w, tag, "cur_cnt", cur_cnt, j_cnt - w);
        if (j_long != 0) begin
            chk(int'(cur_src) == j_src, tag, "cur_src fixed", cur_src, j_src);
            chk(int'(cur_dst) == j_dst, tag, "cur_dst fixed", cur_dst, j_dst);
            chk(int'(cur_off) == ((j_off + w) & 255), tag, "cur_off", cur_off, (j_off + w) & 255);
        end else begin
            chk(int'(cur_src) == ((j_src + w) & 255), tag, "cur_src", cur_src, (j_src + w) & 255);
            chk(int'(cur_dst) == ((j_dst + w) & 255), tag, "cur_dst", cur_dst, (j_dst + w) & 255);
            chk(int'(cur_off) == j_off, tag, "cur_off unchanged", cur_off, j_off);
        end
    endtask

    task automatic run_job(input int lng, input int s, input int d, input int h,
                           input int o, input int c, input int irqm,
                           input int err_after, input bit bogus);
        int cs, cd, co, cc, w0, a0, guard;
        bit finished;
        j_long = lng; j_src = s; j_dst = d; j_dhi = (lng != 0) ? h : 0; j_off = o; j_cnt = c;
        for (int i = 0; i < MEMN; i++) gold[i] = mem[i];
        w_cnt = 0;
        err_cd = err_after;
        irq_mode = irqm;
        cs = s; cd = d; co = o; cc = c;
        finished = 1'b0;
        for (int stop = 0; stop < 400 && !finished; stop++) begin
            w0 = w_cnt;
            a0 = acc_cnt;
            err_fired = 0;
            pulse_start(lng, cs, cd, h, co, cc);
            if (bogus && stop == 0) begin
                repeat (6) @(negedge clk);
                pulse_start(lng ^ 1, 200, 7, 3, 9, 2);
            end
            guard = 0;
            while (!(done || suspended) && guard < 5000) begin
                @(negedge clk);
                guard++;
            end
            chk(done || suspended, "R7", "copy stops", guard, 5000);
            chk(!(done && suspended), "R9", "pulses exclusive", done, 0);
            check_regs((lng != 0) ? "R5" : "R4");
            if (cc == 0) begin
                chk(done, "R2", "zero count ends in done", done, 1);
                chk(acc_cnt == a0, "R2", "zero count accesses", acc_cnt - a0, 0);
            end
            if (err_fired != 0) begin
                chk(suspended, "R8", "error yields", suspended, 1);
                chk(int'(cur_cnt) == j_cnt - w_cnt, "R8", "rolled-back count", cur_cnt, j_cnt - w_cnt);
            end else if (irqm == 1 && cc > 0) begin
                chk(w_cnt - w0 == 1, "R6", "one word per start under held interrupt", w_cnt - w0, 1);
                chk(suspended, "R6", "yield on interrupt", suspended, 1);
            end
            if (done) begin
                finished = 1'b1;
                chk(w_cnt == j_cnt, "R7", "total words written", w_cnt, j_cnt);
                if (bogus) chk(w_cnt == j_cnt, "R10", "mid-copy start ignored", w_cnt, j_cnt);
            end else begin
                cs = int'(cur_src); cd = int'(cur_dst); co = int'(cur_off); cc = int'(cur_cnt);
            end
            @(negedge clk);
            chk(!done && !suspended, "R9", "single-cycle pulse", {done, suspended}, 0);
        end
        irq_mode = 0;
        err_cd = -1;
        for (int i = 0; i < j_cnt; i++) begin
            chk(mem[exp_wr(i)] == gold[exp_rd(i)], "R7", "destination word",
                mem[exp_wr(i)], gold[exp_rd(i)]);
        end
        chk(mem[exp_wr(j_cnt)] == gold[exp_wr(j_cnt)], "R7", "word past end untouched",
            mem[exp_wr(j_cnt)], gold[exp_wr(j_cnt)]);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R7 watchdog expired: actual=0 expected=1");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < MEMN; i++) mem[i] = DW'($urandom);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!done && !suspended, "R1", "pulses after reset", {done, suspended}, 0);
        chk(!mem_req, "R1", "no request after reset", mem_req, 0);
        chk(cur_cnt == '0 && cur_src == '0, "R1", "count/src after reset", cur_cnt, 0);
        chk(cur_dst == '0 && cur_off == '0, "R1", "dst/off after reset", cur_dst, 0);

        // Directed corner cases
        run_job(0, 10, 140, 0, 0, 0, 0, -1, 1'b0);   // R2 zero count, plain
        run_job(1, 5, 20, 2, 3, 0, 0, -1, 1'b0);     // R2 zero count, long
        run_job(0, 3, 150, 0, 0, 5, 0, -1, 1'b0);    // R4 plain copy
        run_job(1, 250, 40, 1, 4, 6, 0, -1, 1'b0);   // R5 long copy with wrap
        run_job(0, 20, 160, 0, 0, 4, 1, -1, 1'b0);   // R6 held interrupt
        run_job(1, 8, 30, 3, 2, 3, 1, -1, 1'b0);     // R6 long, held interrupt
        run_job(0, 30, 170, 0, 0, 4, 0, 2, 1'b0);    // R8 read error on word 1
        run_job(0, 40, 180, 0, 0, 4, 0, 1, 1'b0);    // R8 write error on word 0
        run_job(1, 12, 50, 2, 1, 5, 0, 3, 1'b0);     // R8 long, write error on word 1
        run_job(0, 50, 130, 0, 0, 12, 0, -1, 1'b1);  // R10 start while busy

        // Constrained random jobs
        for (int n = 0; n < 30; n++) begin
            int lng, s, d, h, o, c, im, ea;
            lng = int'($urandom % 2);
            c   = int'($urandom % 41);
            im  = int'($urandom % 3);
            ea  = (($urandom % 4) == 0) ? int'($urandom % (2 * c + 1)) : -1;
            if (lng != 0) begin
                s = int'($urandom % 32);
                o = int'($urandom % 16);
                d = int'($urandom % 64);
                h = 1 + int'($urandom % 3);
            end else begin
                s = int'($urandom % 64);
                d = 128 + int'($urandom % 64);
                o = int'($urandom % 256);
                h = int'($urandom % 4);
            end
            run_job(lng, s, d, h, o, c, im, ea, 1'b0);
        end
        finish_run();
    end

endmodule